// File: doc/BRIEF.md
# Event Latch and Interrupt Aggregator

This block gathers twenty-four raw fault and status sources from a multi-output regulator controller and turns each one into a sticky event bit. It detects the rising edge of each source and sets the matching bit, which then stays set until software clears it. The bits sit in three byte-wide event registers on a simple register bus. A bit is cleared by writing a 1 to it. Writing a 0 has no effect on it.

Each event byte has a mask byte beside it in its own address window. A mask bit of 1 hides the event from the interrupt, and a mask bit of 0 lets it through. After reset every mask bit is 1. One active-low interrupt line is low while any event bit is set and its mask bit is 0.

The lowest event byte holds the base events. One of these, bit 6, is the reference-voltage event, which also fires whenever the base supply is switched off. The middle byte holds one overcurrent bit per regulator. The top byte holds one power-good-fail bit per regulator. Inside each of these two bytes, regulator n uses bit n-1. How the sources are produced is outside this block. The block takes them as synchronous levels.

Top module: `evt_irq_agg`

## Requirements
- R1: A synchronous active-high reset clears every event bit. It sets every mask bit to 1. It drives irq_n high and bus_rdata to 0.
- R2: A 0-to-1 change of a raw_evt bit, seen between two rising clock edges, sets the matching event bit at the second edge. A level that stays high does not set the bit again after it is cleared. A level that is already high when reset is released is not an event.
- R3: The event bytes are mapped as follows, and the bench checks this layout.
  - Address 0x10 holds raw bits 7:0 (base events; bit 6 is the reference-voltage event).
  - Address 0x11 holds raw bits 15:8. Regulator n overcurrent is bit 8+n-1.
  - Address 0x12 holds raw bits 23:16. Regulator n power-good-fail is bit 16+n-1.
- R4: A write to an event byte clears each bit written as 1. Each bit written as 0 is left unchanged.
- R5: If a rising edge and a write-1 clear hit the same event bit in the same cycle, the bit ends up set.
- R6: The mask bytes sit at 0x16, 0x17 and 0x18. Each covers the same bits as the event byte six addresses below it. A write stores the byte, and a read returns it. A masked event stays latched but does not pull irq_n low.
- R7: irq_n is registered. At each clock edge it becomes low if the register state before that edge has an event bit set with its mask bit at 0. Otherwise it becomes high.
- R8: Reads are registered. bus_rdata shows the addressed register one cycle after bus_rd, using the state before that edge. It is 0 in any cycle with no read. Addresses outside the two windows read 0, and writes to them change nothing.
- R9: Writing 0xFF to all three event bytes clears every event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_evt | input | 24 | Raw event sources, level, synchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
In one cycle a source can rise while software writes a 1 to clear that same bit. The bench forces this case: it drops a source, then raises it again in the same cycle as a clearing write to its byte. A readback must then show the bit set. The random phase gives each cycle a chance of raising sources and writing clears or masks together, and a reference model applies the rule that a set wins over a clear to judge every readback and every interrupt level.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int GRP_W_DEF    = 8;
  localparam int N_GROUPS_DEF = 3;
  localparam int ADDR_W_DEF   = 8;
  localparam int EVT_BASE_DEF = 'h10;
  localparam int MASK_BASE_DEF = 'h16;
endpackage

// File: rtl/evt_grp.sv
module evt_grp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] evt
);
  logic [W-1:0] raw_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr;

  assign rise = raw & ~raw_q;
  assign clr  = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= raw;
      evt   <= '0;
    end else begin
      raw_q <= raw;
      evt   <= (evt & ~clr) | rise;
    end
  end
endmodule

// File: rtl/mask_grp.sv
module mask_grp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= '1;
    else if (we) mask <= wdata;
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int GRP_W     = GRP_W_DEF,
  parameter int N_GROUPS  = N_GROUPS_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int EVT_BASE  = EVT_BASE_DEF,
  parameter int MASK_BASE = MASK_BASE_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_GROUPS*GRP_W-1:0] raw_evt,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [GRP_W-1:0]          bus_wdata,
  output logic [GRP_W-1:0]          bus_rdata,
  output logic                      irq_n
);
  localparam int EVT_W = N_GROUPS * GRP_W;

  logic [EVT_W-1:0]    evt_q;
  logic [EVT_W-1:0]    mask_q;
  logic [N_GROUPS-1:0] evt_hit;
  logic [N_GROUPS-1:0] mask_hit;
  logic [GRP_W-1:0]    rd_mux;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(EVT_BASE + g);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_BASE + g);

    assign evt_hit[g]  = (bus_addr == EA);
    assign mask_hit[g] = (bus_addr == MA);

    evt_grp #(.W(GRP_W)) u_evt (
      .clk      (clk),
      .rst      (rst),
      .raw      (raw_evt[g*GRP_W +: GRP_W]),
      .clr_en   (bus_wr & evt_hit[g]),
      .clr_bits (bus_wdata),
      .evt      (evt_q[g*GRP_W +: GRP_W])
    );

    mask_grp #(.W(GRP_W)) u_mask (
      .clk   (clk),
      .rst   (rst),
      .we    (bus_wr & mask_hit[g]),
      .wdata (bus_wdata),
      .mask  (mask_q[g*GRP_W +: GRP_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (evt_hit[g])  rd_mux = rd_mux | evt_q[g*GRP_W +: GRP_W];
      if (mask_hit[g]) rd_mux = rd_mux | mask_q[g*GRP_W +: GRP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      irq_n     <= ~|(evt_q & ~mask_q);
    end
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int GRP_W     = 8,
  parameter int N_GROUPS  = 3,
  parameter int ADDR_W    = 8,
  parameter int EVT_BASE  = 'h10,
  parameter int MASK_BASE = 'h16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_GROUPS*GRP_W-1:0] raw_evt,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [GRP_W-1:0]          bus_rdata,
  input logic                      irq_n,
  input logic [N_GROUPS*GRP_W-1:0] evt_q,
  input logic [N_GROUPS*GRP_W-1:0] mask_q
);
  localparam int EVT_W = N_GROUPS * GRP_W;
  localparam logic [ADDR_W-1:0] E_LO = ADDR_W'(EVT_BASE);
  localparam logic [ADDR_W-1:0] E_HI = ADDR_W'(EVT_BASE + N_GROUPS);
  localparam logic [ADDR_W-1:0] M_LO = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] M_HI = ADDR_W'(MASK_BASE + N_GROUPS);

  logic [EVT_W-1:0] prev_raw;
  logic [EVT_W-1:0] rise;
  logic             mapped;

  always_ff @(posedge clk) prev_raw <= raw_evt;
  assign rise   = raw_evt & ~prev_raw;
  assign mapped = (bus_addr >= E_LO && bus_addr < E_HI) ||
                  (bus_addr >= M_LO && bus_addr < M_HI);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (evt_q == '0 && mask_q == '1 && irq_n && bus_rdata == '0));

  assert_rise_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((evt_q & $past(rise)) == $past(rise)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ((evt_q & ~$past(evt_q) & ~$past(rise)) == '0));

  assert_mask_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(mask_q));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_n == ~|($past(evt_q) & ~$past(mask_q))));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .GRP_W(GRP_W), .N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W),
  .EVT_BASE(EVT_BASE), .MASK_BASE(MASK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .raw_evt(raw_evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_n(irq_n),
  .evt_q(evt_q), .mask_q(mask_q)
);

// File: tb/tb_evt_irq_agg.sv
`timescale 1ns/1ps
module tb_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] raw = 24'h000001;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic [7:0]  rdata;
  logic        irq_n;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [23:0] m_evt, m_mask, m_prev;
  logic        e_irq_n;
  logic [7:0]  e_rdata;

  always #5 clk = ~clk;

  evt_irq_agg dut (
    .clk(clk), .rst(rst), .raw_evt(raw), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h12) return m_evt[(a - 8'h10) * 8 +: 8];
    if (a >= 8'h16 && a <= 8'h18) return m_mask[(a - 8'h16) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, outputs checked at the following negedge
  task automatic step(input string tag);
    logic [23:0] clr;
    @(posedge clk);
    if (rst) begin
      m_evt = '0; m_mask = '1; m_prev = raw; e_irq_n = 1'b1; e_rdata = 8'h00;
    end else begin
      e_irq_n = ~|(m_evt & ~m_mask);
      e_rdata = rd ? model_read(addr) : 8'h00;
      clr = '0;
      if (wr && addr >= 8'h10 && addr <= 8'h12) clr[(addr - 8'h10) * 8 +: 8] = wdata;
      m_evt = (m_evt & ~clr) | (raw & ~m_prev);
      if (wr && addr >= 8'h16 && addr <= 8'h18) m_mask[(addr - 8'h16) * 8 +: 8] = wdata;
      m_prev = raw;
    end
    @(negedge clk);
    check({tag, " irq"}, {31'd0, irq_n}, {31'd0, e_irq_n});
    check({tag, " rdata"}, {24'd0, rdata}, {24'd0, e_rdata});
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr = 1'b1; addr = a; wdata = d; step(tag);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd = 1'b1; addr = a; step(tag);
    check({tag, " direct"}, {24'd0, rdata}, {24'd0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step("R1 reset"); step("R1 reset"); step("R1 reset");
    rst = 1'b0;
    step("R1 idle");
    check("R1 irq after reset", {31'd0, irq_n}, 32'd1);
    bus_read(8'h16, 8'hFF, "R1 mask reset");
    bus_read(8'h10, 8'h00, "R2 level at reset");

    bus_write(8'h16, 8'h00, "R6 unmask");
    bus_write(8'h17, 8'h00, "R6 unmask");
    bus_write(8'h18, 8'h00, "R6 unmask");
    step("R7 no event");
    check("R7 irq idle", {31'd0, irq_n}, 32'd1);

    raw[10] = 1'b1;
    step("R2 rise"); step("R7 pend");
    check("R7 irq low", {31'd0, irq_n}, 32'd0);
    bus_read(8'h11, 8'h04, "R3 regulator 3 overcurrent");

    bus_write(8'h11, 8'hFB, "R4 zero write");
    bus_read(8'h11, 8'h04, "R4 zero keeps");
    bus_write(8'h11, 8'h04, "R4 one clears");
    step("R2 held level");
    bus_read(8'h11, 8'h00, "R2 no re-set");

    raw[10] = 1'b0; step("R5 drop");
    raw[10] = 1'b1; bus_write(8'h11, 8'h04, "R5 collide");
    bus_read(8'h11, 8'h04, "R5 set wins");

    raw[6] = 1'b1; raw[16] = 1'b1; raw[23] = 1'b1;
    step("R3 rise");
    bus_read(8'h10, 8'h40, "R3 reference-voltage bit 6");
    bus_read(8'h12, 8'h81, "R3 power-good regs 1 and 8");

    bus_write(8'h10, 8'hFF, "R9 clear");
    bus_write(8'h11, 8'hFF, "R9 clear");
    bus_write(8'h12, 8'hFF, "R9 clear");
    step("R9 settle");
    check("R9 irq high", {31'd0, irq_n}, 32'd1);
    bus_read(8'h12, 8'h00, "R9 all clear");

    bus_write(8'h17, 8'h04, "R6 mask reg 3");
    raw[10] = 1'b0; step("R6 drop");
    raw[10] = 1'b1; step("R6 rise"); step("R6 settle");
    check("R6 masked irq", {31'd0, irq_n}, 32'd1);
    bus_read(8'h11, 8'h04, "R6 still latched");
    bus_read(8'h17, 8'h04, "R6 mask readback");

    bus_write(8'h13, 8'hFF, "R8 unmapped write");
    bus_read(8'h13, 8'h00, "R8 unmapped read");
    bus_read(8'h11, 8'h04, "R8 unmapped write ignored");

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] sel;
      if (($urandom % 3) == 0) raw = raw ^ (24'(1) << ($urandom % 24));
      sel = 8'($urandom % 8);
      case ($urandom % 3)
        0: begin
          wr = 1'b1;
          addr = (sel < 3) ? 8'h10 + sel : (sel < 6) ? 8'h16 + sel - 3 : 8'h14;
          wdata = 8'($urandom);
        end
        1: begin
          rd = 1'b1;
          addr = (sel < 3) ? 8'h10 + sel : (sel < 6) ? 8'h16 + sel - 3 : 8'h19;
        end
        default: ;
      endcase
      step("R5 R7 R8 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule